// File: doc/BRIEF.md
# Clock Slice Synchronization Controller

This block derives several divided clock slices from one fast source clock. Each slice is modelled as a one-cycle clock-enable pulse in the source domain. Each slice has its own enable and its own 4-bit integer divide ratio. A slice whose ratio is 5, for example, pulses once every five source cycles.

A synchronization request brings every enabled slice into phase. Raising the request stops the slices and clears their status bits. The controlling logic waits for the acknowledge, which means every status has reached 0, and then withdraws the request. In the cycle after the withdrawal is sampled, every enabled slice restarts its counter from zero. All of them pulse together in that cycle, and from then on their rising edges stay aligned.

A divide ratio is captured only while a slice is not running. A new ratio written to a running slice therefore waits for the next synchronization or the next re-enable.

Top module: `clk_slice_sync`

## Requirements
- R1: One cycle after the sync request is sampled high at a clock edge, the status of every slice is 0.
- R2: One cycle after the sync request is sampled high, no slice pulses, and no slice pulses while the request stays high.
- R3: `sync_ack` is 1 exactly when `sync_req` is 1 and every status bit is 0.
- R4: At the first edge where an enabled slice samples the request low after being held, its counter restarts from zero. In the cycle after that edge, the slice's status is 1 and it pulses when its ratio is nonzero. All enabled slices released at the same edge therefore pulse in the same cycle.
- R5: A running slice with ratio N (1 to 15) pulses once every N cycles. The first pulse is in the cycle after it starts.
- R6: A ratio of 0 gates the slice: it never pulses and reports status 0.
- R7: A disabled slice never pulses, reports status 0, and is unaffected by the sync request.
- R8: The ratio on `div_val` is captured at each edge where the slice is held (disabled or under request) and at its start edge. Changes made while the slice is running have no effect until it is held again.
- R9: While `rst_n` is low, all pulses and status bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_req | input | 1 | Synchronization request |
| slice_en | input | NUM_SLICES | Per-slice enable |
| div_val | input | NUM_SLICES*4 | Per-slice divide ratio; slice i uses bits [4i+3:4i] |
| slice_pulse | output | NUM_SLICES | Per-slice clock-enable pulse |
| slice_stat | output | NUM_SLICES | Per-slice running status |
| sync_ack | output | 1 | Request acknowledged: all status bits are 0 |

## Verification
The bench changes ratios while slices are running. A design that applied the new ratio at once would drift out of phase with the model inside the next period. The bench releases a request with mixed ratios, including 1 and 0. A design that restarted counters from a stale phase, or let a gated slice report running, would break the shared first pulse or show a stray status bit. Disabled slices and a mid-run enable are also exercised, to catch a design that lets the request disturb slices that are off.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int CS_DIV_W = 4;
  typedef logic [CS_DIV_W-1:0] div_t;

  // Next phase of a slice counter that wraps at ratio d.
  function automatic div_t cs_next_count(input div_t c, input div_t d);
    if (d == '0) return '0;
    if (c >= d - div_t'(1)) return '0;
    return c + div_t'(1);
  endfunction

  // A slice fires when its phase is zero and its ratio is nonzero.
  function automatic logic cs_phase_zero(input div_t c, input div_t d);
    return (d != '0) && (c == '0);
  endfunction
endpackage

// File: rtl/cs_slice.sv
module cs_slice
  import cs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_req,
  input  div_t div_in,
  output logic tick,
  output logic stat
);
  logic run_q;
  div_t div_q;
  div_t cnt_q;
  logic start_ev;

  assign start_ev = run_req & ~run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      div_q <= '0;
    end else if (!run_req) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      div_q <= div_in;
    end else if (start_ev) begin
      run_q <= 1'b1;
      cnt_q <= '0;
      div_q <= div_in;
    end else begin
      cnt_q <= cs_next_count(cnt_q, div_q);
    end
  end

  assign tick = run_q & cs_phase_zero(cnt_q, div_q);
  assign stat = run_q & (div_q != '0);
endmodule

// File: rtl/cs_ack.sv
module cs_ack #(
  parameter int NUM_SLICES = 4
) (
  input  logic                  sync_req,
  input  logic [NUM_SLICES-1:0] stat,
  output logic                  ack
);
  assign ack = sync_req & ~(|stat);
endmodule

// File: rtl/clk_slice_sync.sv
module clk_slice_sync
  import cs_pkg::*;
#(
  parameter int NUM_SLICES = 4,
  localparam int DIV_BUS_W = NUM_SLICES * CS_DIV_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sync_req,
  input  logic [NUM_SLICES-1:0] slice_en,
  input  logic [DIV_BUS_W-1:0]  div_val,
  output logic [NUM_SLICES-1:0] slice_pulse,
  output logic [NUM_SLICES-1:0] slice_stat,
  output logic                  sync_ack
);
  logic [NUM_SLICES-1:0] run_req;

  for (genvar gi = 0; gi < NUM_SLICES; gi++) begin : g_slice
    assign run_req[gi] = slice_en[gi] & ~sync_req;
    cs_slice u_slice (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_req(run_req[gi]),
      .div_in (div_val[gi*CS_DIV_W +: CS_DIV_W]),
      .tick   (slice_pulse[gi]),
      .stat   (slice_stat[gi])
    );
  end

  cs_ack #(.NUM_SLICES(NUM_SLICES)) u_ack (
    .sync_req(sync_req),
    .stat    (slice_stat),
    .ack     (sync_ack)
  );
endmodule

// File: rtl/cs_sync_chk.sv
module cs_sync_chk #(
  parameter int NUM_SLICES = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sync_req,
  input logic [NUM_SLICES-1:0] slice_en,
  input logic [NUM_SLICES-1:0] slice_pulse,
  input logic [NUM_SLICES-1:0] slice_stat,
  input logic                  sync_ack
);
  assert_status_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sync_req) |-> (slice_stat == '0));

  assert_no_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sync_req) |-> (slice_pulse == '0));

  assert_ack_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_req && $past(sync_req)) |-> sync_ack);

  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((~$past(slice_en)) & (slice_pulse | slice_stat)) == '0);

  for (genvar gi = 0; gi < NUM_SLICES; gi++) begin : g_chk
    assert_aligned_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(slice_stat[gi]) |-> slice_pulse[gi]);
  end
endmodule

bind clk_slice_sync cs_sync_chk #(.NUM_SLICES(NUM_SLICES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sync_req   (sync_req),
  .slice_en   (slice_en),
  .slice_pulse(slice_pulse),
  .slice_stat (slice_stat),
  .sync_ack   (sync_ack)
);

// File: tb/sim_clk_slice_sync.sv
module sim_clk_slice_sync;
  localparam int CLK_P = 10;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_req = 1'b0;
  logic [NS-1:0] slice_en = '0;
  logic [NS*4-1:0] div_val = '0;
  logic [NS-1:0] slice_pulse, slice_stat;
  logic sync_ack;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  string phase = "R9";

  int m_run [NS];
  int m_cnt [NS];
  int m_dv  [NS];

  always #(CLK_P/2) clk = ~clk;

  clk_slice_sync #(.NUM_SLICES(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .slice_en(slice_en),
    .div_val(div_val), .slice_pulse(slice_pulse), .slice_stat(slice_stat),
    .sync_ack(sync_ack)
  );

  // Behavioural reference: each slice is "running" with a phase modulo its ratio.
  always @(posedge clk) begin
    for (int i = 0; i < NS; i++) begin
      if (!rst_n) begin
        m_run[i] = 0; m_cnt[i] = 0; m_dv[i] = 0;
      end else if (!(slice_en[i] && !sync_req)) begin
        m_run[i] = 0; m_cnt[i] = 0; m_dv[i] = int'(div_val[i*4 +: 4]);
      end else if (m_run[i] == 0) begin
        m_run[i] = 1; m_cnt[i] = 0; m_dv[i] = int'(div_val[i*4 +: 4]);
      end else begin
        m_cnt[i] = (m_dv[i] == 0) ? 0 : (m_cnt[i] + 1) % m_dv[i];
      end
    end
  end

  task automatic compare_now();
    logic [NS-1:0] ep, es;
    logic ea;
    for (int i = 0; i < NS; i++) begin
      es[i] = (m_run[i] != 0) && (m_dv[i] != 0);
      ep[i] = es[i] && (m_cnt[i] == 0);
    end
    ea = sync_req && (es == '0);
    compared++;
    if (slice_pulse !== ep) begin
      mismatched++;
      $display("FAIL %s pulse actual=%b expected=%b t=%0t", phase, slice_pulse, ep, $time);
    end
    compared++;
    if (slice_stat !== es) begin
      mismatched++;
      $display("FAIL %s status actual=%b expected=%b t=%0t", phase, slice_stat, es, $time);
    end
    compared++;
    if (sync_ack !== ea) begin
      mismatched++;
      $display("FAIL %s ack actual=%b expected=%b t=%0t", phase, sync_ack, ea, $time);
    end
  endtask

  task automatic run_cycles(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
      compare_now();
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    mismatched++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    // R9: reset state
    phase = "R9";
    slice_en = 4'b1111; div_val = 16'h4321;
    run_cycles(3);
    @(negedge clk); rst_n = 1'b1;
    // R5: ratios 1,2,3,4 running
    phase = "R5";
    run_cycles(24);
    // R8: ratio change while running is deferred
    phase = "R8";
    div_val = 16'h3215;
    run_cycles(20);
    // R1/R2/R3: request held
    phase = "R1";
    sync_req = 1'b1;
    run_cycles(1);
    phase = "R2";
    run_cycles(3);
    phase = "R3";
    run_cycles(2);
    // R4: release, all restart aligned with new ratios
    phase = "R4";
    sync_req = 1'b0;
    run_cycles(30);
    // R6: gated slice
    phase = "R6";
    div_val = 16'h3015;
    sync_req = 1'b1; run_cycles(3);
    sync_req = 1'b0; run_cycles(15);
    // R7: disabled slices ignore sync
    phase = "R7";
    slice_en = 4'b1010; div_val = 16'h2736;
    run_cycles(5);
    sync_req = 1'b1; run_cycles(3);
    sync_req = 1'b0; run_cycles(15);
    // R5: mid-run enable starts its own count
    phase = "R5";
    slice_en = 4'b1111;
    run_cycles(20);
    // R4: mixed traffic
    phase = "R4";
    for (int j = 0; j < 300; j++) begin
      if ((j % 7) == 0) div_val = 16'($urandom);
      if ((j % 11) == 0) slice_en = 4'($urandom);
      if ((j % 23) == 0) sync_req = 1'b1;
      if ((j % 23) == 4) sync_req = 1'b0;
      run_cycles(1);
    end
    finish_run();
  end
endmodule